// File: doc/BRIEF.md
# Serial Audio Link Codec-Side Frame Controller

This block is the codec end of a five-wire serial audio link. It runs from a master clock at twice the bit rate and divides it by two to make the bit clock that the link controller uses. It follows the frame sync and samples the incoming serial stream on the falling bit-clock edge. It drives the outgoing serial stream on the rising edge. A frame is 256 bits: a 16-bit tag slot, then twelve 20-bit slots, most significant bit first. The bit during which sync is first seen high is tag bit 0.

Register writes carried in slots 1 and 2 are decoded and presented as a one-cycle parallel strobe with a 7-bit index and 16 bits of data. A committed write to index 0x26 with data bit 12 set is a link power-down request. The block then parks the bit clock and the outgoing data line low. A high-then-low pulse on sync brings the link back without clearing anything (warm reset). An asynchronous low reset clears all state (cold reset). A defined pin state at reset release selects a test mode in which the link outputs should be released.

Top module: `serial_link_codec`

## Requirements
- R1: While rst_ni is low, bclk_o, ser_tx_o, wr_valid_o and pdown_o are all 0 and bclk_o does not toggle.
- R2: After reset release in normal mode, bclk_o toggles on every master-clock edge, so its period is two master clocks; link_oe_o is 1.
- R3: If ser_rx_i is 1 and sync_i is 0 at the first master-clock edge after reset release, the block enters test mode: link_oe_o is 0 and bclk_o stays low until the next cold reset.
- R4: Inputs are sampled at each falling bit-clock edge. A sample with sync_i 1 after a sample with sync_i 0 is frame bit 0, and later bits are counted from it. Frame bit 1 is the slot 1 valid flag and frame bit 2 is the slot 2 valid flag.
- R5: Slot 1 occupies frame bits 16..35: bit 16 is read(1)/write(0) and bits 17..23 are the register index, MSB first. Slot 2 occupies frame bits 36..55, and bits 36..51 are the write data, MSB first.
- R6: A write is committed only when both valid flags are 1 and the read/write bit is 0. wr_valid_o is then high for exactly one master clock, starting one master clock after the falling edge that samples frame bit 55, with wr_addr_o and wr_data_o holding the decoded fields.
- R7: ser_tx_o changes only at a rising bit-clock edge. In the outgoing frame, the codec-ready flag is 1 for the single bit period that starts at the first rising edge after frame bit 0 is sampled, and every other bit is 0.
- R8: A committed write to index 0x26 with data bit 12 set stops the link after slot 2: bclk_o makes no further rising edge, ser_tx_o stays 0, and pdown_o is 1.
- R9: While stopped, sync_i going high does not restart the clock. Its following fall restarts bclk_o and clears pdown_o. The codec-ready flag and the decode path work again in the next frame without a cold reset.
- R10: Committed writes to any other index, or to index 0x26 with data bit 12 clear, leave the link running with pdown_o 0.

Top module ports in declaration order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, twice the bit rate |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| sync_i | input | 1 | Frame sync from the link controller |
| ser_rx_i | input | 1 | Serial data from controller to codec |
| bclk_o | output | 1 | Bit clock |
| ser_tx_o | output | 1 | Serial data from codec to controller |
| link_oe_o | output | 1 | Output enable for bclk_o and ser_tx_o pads; 0 in test mode |
| wr_valid_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register index of the write |
| wr_data_o | output | 16 | Register write data |
| pdown_o | output | 1 | Link is powered down, bit clock stopped |

## Verification
The decode is tried with all eight combinations of the two slot-valid flags and the read/write bit. Each carries a distinct index and data word, so a commit from the wrong combination or a field taken from the wrong bits shows up as a count or value mismatch. A further sweep of indices with inverted data patterns separates adjacent bit positions. Writes to other indices with bit 12 set, and to index 0x26 with bit 12 clear, separate the power-down match from either half of it. The stop is checked by counting bit-clock edges after slot 2, and the warm restart by checking that a held-high sync alone does nothing before its fall does.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic [1:0] {
    LNK_INIT,
    LNK_RUN,
    LNK_STOP,
    LNK_TEST
  } lnk_state_e;
endpackage

// File: rtl/link_clk.sv
module link_clk
  import link_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic ser_rx_i,
  input  logic pdn_req_i,
  output logic bclk_o,
  output logic fall_o,
  output logic rise_o,
  output logic ready_o,
  output logic stopped_o,
  output logic oe_o
);
  lnk_state_e st_q;
  logic       ph_q;
  logic       wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= LNK_INIT;
      ph_q   <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      unique case (st_q)
        LNK_INIT: st_q <= (ser_rx_i && !sync_i) ? LNK_TEST : LNK_RUN;
        LNK_RUN: begin
          if (pdn_req_i) begin
            st_q <= LNK_STOP;
            ph_q <= 1'b0;
          end else begin
            ph_q <= ~ph_q;
          end
        end
        LNK_STOP: begin
          if (sync_i) wake_q <= 1'b1;
          else if (wake_q) begin
            wake_q <= 1'b0;
            st_q   <= LNK_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  assign bclk_o    = ph_q;
  assign fall_o    = (st_q == LNK_RUN) && ph_q;
  assign rise_o    = (st_q == LNK_RUN) && !ph_q && !pdn_req_i;
  assign ready_o   = (st_q == LNK_RUN) || (st_q == LNK_STOP);
  assign stopped_o = (st_q == LNK_STOP);
  assign oe_o      = (st_q != LNK_TEST);

  AST_TEST_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !bclk_o); // R3
  AST_STOP_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |-> !bclk_o); // R8
  AST_WAKE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stopped_o) |-> !$past(sync_i)); // R9
endmodule

// File: rtl/link_rx.sv
module link_rx #(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16,
  parameter int PDN_ADDR  = 'h26,
  parameter int PDN_BIT   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              stopped_i,
  input  logic              sync_i,
  input  logic              ser_rx_i,
  output logic              sof_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              pdn_req_o
);
  localparam int FRAME_BITS = TAG_BITS + NUM_SLOTS * SLOT_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int S1_END     = TAG_BITS + SLOT_BITS - 1;
  localparam int S2_END     = TAG_BITS + 2 * SLOT_BITS - 1;

  logic [CNT_W-1:0]     idx_q, cur;
  logic [SLOT_BITS-2:0] shift_q;
  logic                 sync_q, lock_q, v1_q, v2_q, rw_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    data_n;

  assign sof_o  = fall_i && sync_i && !sync_q;
  assign cur    = sof_o ? '0 : idx_q;
  assign data_n = shift_q[SLOT_BITS-2 -: DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      shift_q    <= '0;
      sync_q     <= 1'b0;
      lock_q     <= 1'b0;
      v1_q       <= 1'b0;
      v2_q       <= 1'b0;
      rw_q       <= 1'b1;
      addr_q     <= '0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      pdn_req_o  <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      pdn_req_o  <= 1'b0;
      if (stopped_i) lock_q <= 1'b0;
      if (fall_i) begin
        sync_q  <= sync_i;
        shift_q <= {shift_q[SLOT_BITS-3:0], ser_rx_i};
        idx_q   <= (cur == CNT_W'(FRAME_BITS - 1)) ? '0 : cur + 1'b1;
        if (sof_o) lock_q <= 1'b1;
        if (cur == CNT_W'(1)) v1_q <= ser_rx_i;
        if (cur == CNT_W'(2)) v2_q <= ser_rx_i;
        if (cur == CNT_W'(S1_END)) begin
          rw_q   <= shift_q[SLOT_BITS-2];
          addr_q <= shift_q[SLOT_BITS-3 -: ADDR_W];
        end
        // commit at the last bit of slot 2
        if (cur == CNT_W'(S2_END) && lock_q && v1_q && v2_q && !rw_q) begin
          wr_valid_o <= 1'b1;
          wr_addr_o  <= addr_q;
          wr_data_o  <= data_n;
          pdn_req_o  <= (addr_q == ADDR_W'(PDN_ADDR)) && data_n[PDN_BIT];
        end
      end
    end
  end

  AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o); // R6
  AST_WR_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(fall_i)); // R6
endmodule

// File: rtl/link_tx.sv
module link_tx (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic rise_i,
  input  logic sof_i,
  input  logic ready_i,
  input  logic stopped_i,
  output logic ser_tx_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      ser_tx_o <= 1'b0;
    end else begin
      if (fall_i) pend_q <= sof_i && ready_i;
      if (stopped_i)   ser_tx_o <= 1'b0;
      else if (rise_i) ser_tx_o <= pend_q;
    end
  end

  AST_TX_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(ser_tx_o) |-> $past(rise_i)); // R7
endmodule

// File: rtl/serial_link_codec.sv
module serial_link_codec #(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16,
  parameter int PDN_ADDR  = 'h26,
  parameter int PDN_BIT   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              ser_rx_i,
  output logic              bclk_o,
  output logic              ser_tx_o,
  output logic              link_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              pdown_o
);
  logic fall, rise, ready, stopped, sof, pdn_req;

  link_clk u_clk (
    .clk_i, .rst_ni, .sync_i, .ser_rx_i,
    .pdn_req_i (pdn_req),
    .bclk_o,
    .fall_o    (fall),
    .rise_o    (rise),
    .ready_o   (ready),
    .stopped_o (stopped),
    .oe_o      (link_oe_o)
  );

  link_rx #(
    .TAG_BITS (TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS),
    .ADDR_W   (ADDR_W),   .DATA_W   (DATA_W),
    .PDN_ADDR (PDN_ADDR), .PDN_BIT  (PDN_BIT)
  ) u_rx (
    .clk_i, .rst_ni,
    .fall_i    (fall),
    .stopped_i (stopped),
    .sync_i, .ser_rx_i,
    .sof_o     (sof),
    .wr_valid_o, .wr_addr_o, .wr_data_o,
    .pdn_req_o (pdn_req)
  );

  link_tx u_tx (
    .clk_i, .rst_ni,
    .fall_i    (fall),
    .rise_i    (rise),
    .sof_i     (sof),
    .ready_i   (ready),
    .stopped_i (stopped),
    .ser_tx_o
  );

  assign pdown_o = stopped;

  AST_PDN_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_req |=> pdown_o); // R8
  AST_PDN_TX_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_o |-> !ser_tx_o); // R8
  AST_PDN_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_o |-> !$rose(bclk_o)); // R8
endmodule

// File: tb/sim_serial_link_codec.sv
module sim_serial_link_codec;
  localparam int CLK_PERIOD = 40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_i = 1'b0;
  logic        ser_rx_i = 1'b0;
  logic        bclk_o, ser_tx_o, link_oe_o, wr_valid_o, pdown_o;
  logic [6:0]  wr_addr_o;
  logic [15:0] wr_data_o;

  int checks = 0;
  int fails = 0;
  int rises = 0;
  int wr_cnt = 0;
  logic [6:0]  last_addr = '0;
  logic [15:0] last_data = '0;

  serial_link_codec u0 (
    .clk_i, .rst_ni, .sync_i, .ser_rx_i, .bclk_o, .ser_tx_o,
    .link_oe_o, .wr_valid_o, .wr_addr_o, .wr_data_o, .pdown_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge bclk_o) rises++;

  always @(negedge clk_i) if (wr_valid_o) begin
    wr_cnt++;
    last_addr = wr_addr_o;
    last_data = wr_data_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives nbits of one frame; reports whether the ready flag sat only at bit 1
  task automatic send_frame(input logic v1, input logic v2, input logic rw,
                            input logic [6:0] addr, input logic [15:0] data,
                            input int nbits, output logic ready_ok);
    logic [19:0] s1, s2;
    logic        saw1, other;
    s1 = {rw, addr, 12'h000};
    s2 = {data, 4'h0};
    saw1 = 1'b0;
    other = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      @(posedge bclk_o);
      #1;
      if (i == 1) saw1 = ser_tx_o;
      else if (ser_tx_o) other = 1'b1;
      sync_i = (i < 16);
      if (i == 0) ser_rx_i = 1'b1;
      else if (i == 1) ser_rx_i = v1;
      else if (i == 2) ser_rx_i = v2;
      else if (i >= 16 && i <= 35) ser_rx_i = s1[35-i];
      else if (i >= 36 && i <= 55) ser_rx_i = s2[55-i];
      else ser_rx_i = 1'b0;
    end
    ready_ok = saw1 && !other;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic ok;
    int   exp_cnt;
    time  t0;
    exp_cnt = 0;

    // R1: cold reset
    repeat (10) @(negedge clk_i);
    chk("R1 bclk in reset", bclk_o, 0);
    chk("R1 tx in reset", ser_tx_o, 0);
    chk("R1 wr_valid in reset", wr_valid_o, 0);
    chk("R1 pdown in reset", pdown_o, 0);
    chk("R1 no bclk edges", rises, 0);
    rst_ni = 1'b1;

    // R2: bit clock period
    @(posedge bclk_o);
    t0 = $time;
    @(posedge bclk_o);
    chk("R2 bclk period", 32'($time - t0), 32'(2 * CLK_PERIOD));
    chk("R2 oe normal", link_oe_o, 1);

    // R6 R4 R5: all tag / rw combinations
    for (int c = 0; c < 8; c++) begin
      logic [6:0]  a;
      logic [15:0] d;
      a = 7'(c * 5 + 2);
      d = 16'(c * 4097 + 'h1000);
      send_frame(c[0], c[1], c[2], a, d, 256, ok);
      if (c[0] && c[1] && !c[2]) begin
        exp_cnt++;
        chk("R6 committed addr", last_addr, a);
        chk("R5 committed data", last_data, d);
      end
      chk("R6 commit count", wr_cnt, exp_cnt);
      chk("R10 no pdown other index", pdown_o, 0);
      if (c == 0) chk("R7 ready flag only at bit 1", ok, 1);
    end

    // R5: index / data position sweep
    for (int k = 0; k < 8; k++) begin
      logic [6:0]  a;
      logic [15:0] d;
      a = 7'(k * 16 + 5);
      d = 16'hFFFF ^ 16'(k * 'h1111);
      send_frame(1'b1, 1'b1, 1'b0, a, d, 256, ok);
      exp_cnt++;
      chk("R5 sweep addr", last_addr, a);
      chk("R5 sweep data", last_data, d);
      chk("R6 sweep count", wr_cnt, exp_cnt);
    end

    // R10: power-down index with bit 12 clear
    send_frame(1'b1, 1'b1, 1'b0, 7'h26, 16'hEFFF, 256, ok);
    exp_cnt++;
    chk("R10 write seen", wr_cnt, exp_cnt);
    chk("R10 still running", pdown_o, 0);
    chk("R7 ready flag", ok, 1);

    // R8: power-down after slot 2
    send_frame(1'b1, 1'b1, 1'b0, 7'h26, 16'h1000, 56, ok);
    repeat (4) @(negedge clk_i);
    exp_cnt++;
    chk("R8 pdown write seen", wr_cnt, exp_cnt);
    chk("R8 pdown flag", pdown_o, 1);
    t0 = time'(rises);
    repeat (200) @(negedge clk_i);
    chk("R8 no bclk edges", 32'(rises) - 32'(t0), 0);
    chk("R8 bclk low", bclk_o, 0);
    chk("R8 tx low", ser_tx_o, 0);

    // R9: warm reset
    sync_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk("R9 held while sync high", 32'(rises) - 32'(t0), 0);
    chk("R9 still down", pdown_o, 1);
    sync_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R9 clock restarted", (32'(rises) - 32'(t0)) > 0, 1);
    chk("R9 pdown cleared", pdown_o, 0);
    send_frame(1'b1, 1'b1, 1'b0, 7'h11, 16'hBEEF, 256, ok);
    exp_cnt++;
    chk("R9 ready kept", ok, 1);
    chk("R9 write after wake", wr_cnt, exp_cnt);
    chk("R9 data after wake", last_data, 16'hBEEF);

    // R1: cold reset clears power-down
    send_frame(1'b1, 1'b1, 1'b0, 7'h26, 16'hFFFF, 56, ok);
    repeat (4) @(negedge clk_i);
    chk("R8 second pdown", pdown_o, 1);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset clears pdown", pdown_o, 0);

    // R3: test mode entry
    ser_rx_i = 1'b1;
    sync_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    t0 = time'(rises);
    repeat (50) @(negedge clk_i);
    chk("R3 oe low", link_oe_o, 0);
    chk("R3 no bclk", 32'(rises) - 32'(t0), 0);
    rst_ni = 1'b0;
    ser_rx_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    chk("R3 normal after reset", link_oe_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule